// File: doc/BRIEF.md
# Miss-Status Holding Register File

This block keeps the table of line fetches that a non-blocking cache has in flight. The cache controller presents each miss with its line address, a request ID, the word offset inside the line and the memory level the fetch goes to. In the same cycle the block does one of three things. It can join the miss to an entry that is already fetching that line, so that no second fetch is issued. It can claim a free entry and issue a fetch tagged with that entry's index. Or it can refuse the miss, and the controller then stalls the miss while hits carry on.

When a fill returns with its tag and the whole line, the block captures the line. It then hands back the waiting requests, one per cycle, in the order they joined. Each response carries the request ID, the selected word and the level the line came from. The entry is free again once its last waiter has been returned.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is in use: `table_full_o`, `fetch_valid_o` and `resp_valid_o` are 0 and `fill_ready_o` is 1.
- R2: A miss whose line matches no entry, while some entry is free, is accepted in the same cycle. In that cycle `fetch_valid_o` is 1, `fetch_line_o` and `fetch_level_o` equal the miss inputs, and `fetch_tag_o` is the lowest-numbered free entry.
- R3: A miss whose line equals the line of an entry in use is accepted as a waiter of that entry, and `fetch_valid_o` stays 0.
- R4: The line address is compared against every entry in use in the same cycle, and at most one entry ever matches.
- R5: An entry holds at most 4 waiters. A miss that would be a fifth waiter is refused (`miss_ready_o` 0, no fetch), and it is not returned when the line arrives.
- R6: With all entries in use, `table_full_o` is 1 and a miss to a new line is refused without a fetch. A miss that merges into an entry with room is still accepted.
- R7: A fill accepted while `fill_ready_o` is 1, for an entry in use, raises `resp_valid_o` from the next cycle on, for exactly as many consecutive cycles as the entry has waiters. The waiters come out in arrival order. Each response carries `resp_id_o`, `resp_level_o` and `resp_data_o`, which is word k of the fill, taken from bits [k*32 +: 32], where k is the waiter's offset.
- R8: An entry becomes free in the cycle after its last waiter is returned. From that cycle `table_full_o` reflects it, and the entry can be allocated again.
- R9: While waiters are being returned, `fill_ready_o` is 0. A miss to the line being returned is refused.
- R10: Several lines can be outstanding at once, and their fills may return in any order.
- R11: A fill whose tag names an entry not in use produces no response and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | A miss is presented |
| miss_line_i | input | 26 | Line address of the miss |
| miss_id_i | input | 4 | Request ID of the miss |
| miss_word_i | input | 3 | Word offset inside the line |
| miss_level_i | input | 2 | Memory level the fetch is sent to |
| miss_ready_o | output | 1 | Miss accepted this cycle (merged or allocated) |
| table_full_o | output | 1 | Every entry is in use |
| fetch_valid_o | output | 1 | A new line fetch is issued this cycle |
| fetch_line_o | output | 26 | Line address to fetch |
| fetch_level_o | output | 2 | Level the fetch goes to |
| fetch_tag_o | output | 3 | Entry index carried by the fetch |
| fill_valid_i | input | 1 | A fill is presented |
| fill_tag_i | input | 3 | Entry index of the returning line |
| fill_data_i | input | 256 | Whole returning line, word k at bits [k*32 +: 32] |
| fill_ready_o | output | 1 | Fill can be taken this cycle |
| resp_valid_o | output | 1 | A waiter is returned this cycle |
| resp_id_o | output | 4 | Request ID of the returned waiter |
| resp_level_o | output | 2 | Level the line was fetched from |
| resp_data_o | output | 32 | Requested word |

## Verification
Misses are sent in several patterns. Two interleaved lines show merging apart from allocation. Four offsets into one line, followed by a fifth miss, exercise the waiter cap. Eight distinct lines followed by a new line and a merge cover table exhaustion. A miss to the line being returned lands exactly on the drain window. Fills return out of issue order with distinct per-word data, so a wrong order, a wrong word or a wrong entry shows up in the response. Freeing one entry of a full table and then allocating again shows whether the lowest free index is chosen, and whether the entry is freed one cycle late. A fill aimed at an empty entry checks that nothing is returned.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    MISS_IDLE  = 2'd0,
    MISS_STALL = 2'd1,
    MISS_MERGE = 2'd2,
    MISS_ALLOC = 2'd3
  } miss_act_e;
endpackage

// File: rtl/mshr_lookup.sv
module mshr_lookup #(
  parameter int N_ENT  = 8,
  parameter int LINE_W = 26,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_ENT-1:0]              valid_i,
  input  logic [N_ENT-1:0][LINE_W-1:0]  lines_i,
  input  logic [LINE_W-1:0]             line_i,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              hit_idx_o,
  output logic                          free_any_o,
  output logic [IDX_W-1:0]              free_idx_o
);
  logic [N_ENT-1:0] match;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (lines_i[g] == line_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < N_ENT; i++)
      if (match[i]) hit_idx_o = IDX_W'(i);
  end

  // lowest free index wins: scan downward
  always_comb begin
    free_idx_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (!valid_i[i]) free_idx_o = IDX_W'(i);
  end

  assign hit_o      = |match;
  assign free_any_o = ~&valid_i;

  AST_ONE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match)); // R4
endmodule

// File: rtl/mshr_entry.sv
module mshr_entry #(
  parameter int LINE_W   = 26,
  parameter int ID_W     = 4,
  parameter int WORD_W   = 3,
  parameter int LVL_W    = 2,
  parameter int MAX_WAIT = 4,
  localparam int CNT_W   = $clog2(MAX_WAIT + 1),
  localparam int WIDX_W  = $clog2(MAX_WAIT)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              alloc_i,
  input  logic                              merge_i,
  input  logic                              free_i,
  input  logic [LINE_W-1:0]                 line_i,
  input  logic [LVL_W-1:0]                  level_i,
  input  logic [ID_W-1:0]                   id_i,
  input  logic [WORD_W-1:0]                 word_i,
  output logic                              valid_o,
  output logic [LINE_W-1:0]                 line_o,
  output logic [LVL_W-1:0]                  level_o,
  output logic [CNT_W-1:0]                  cnt_o,
  output logic [MAX_WAIT-1:0][ID_W-1:0]     ids_o,
  output logic [MAX_WAIT-1:0][WORD_W-1:0]   words_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      line_o  <= '0;
      level_o <= '0;
      cnt_o   <= '0;
      ids_o   <= '0;
      words_o <= '0;
    end else if (alloc_i) begin
      valid_o    <= 1'b1;
      line_o     <= line_i;
      level_o    <= level_i;
      cnt_o      <= CNT_W'(1);
      ids_o[0]   <= id_i;
      words_o[0] <= word_i;
    end else if (merge_i) begin
      ids_o[cnt_o[WIDX_W-1:0]]   <= id_i;
      words_o[cnt_o[WIDX_W-1:0]] <= word_i;
      cnt_o <= cnt_o + CNT_W'(1);
    end else if (free_i) begin
      valid_o <= 1'b0;
      cnt_o   <= '0;
    end
  end

  AST_CNT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CNT_W'(MAX_WAIT)); // R5
  AST_MERGE_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge_i |-> valid_o && !alloc_i); // R3
  AST_ALLOC_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !valid_o); // R2
endmodule

// File: rtl/mshr_drain.sv
module mshr_drain #(
  parameter int N_ENT    = 8,
  parameter int MAX_WAIT = 4,
  parameter int LDATA_W  = 256,
  localparam int IDX_W   = $clog2(N_ENT),
  localparam int CNT_W   = $clog2(MAX_WAIT + 1),
  localparam int WIDX_W  = $clog2(MAX_WAIT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fill_valid_i,
  input  logic [IDX_W-1:0]   fill_tag_i,
  input  logic [LDATA_W-1:0] fill_data_i,
  input  logic               tag_live_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic               fill_ready_o,
  output logic               busy_o,
  output logic [IDX_W-1:0]   tag_o,
  output logic [WIDX_W-1:0]  rel_o,
  output logic [LDATA_W-1:0] data_o,
  output logic               last_o
);
  assign fill_ready_o = !busy_o;
  assign last_o = busy_o && ((CNT_W'(rel_o) + CNT_W'(1)) == cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      tag_o  <= '0;
      rel_o  <= '0;
      data_o <= '0;
    end else if (!busy_o) begin
      if (fill_valid_i && tag_live_i) begin
        busy_o <= 1'b1;
        tag_o  <= fill_tag_i;
        rel_o  <= '0;
        data_o <= fill_data_i;
      end
    end else if (last_o) begin
      busy_o <= 1'b0;
    end else begin
      rel_o <= rel_o + WIDX_W'(1);
    end
  end

  AST_REL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (CNT_W'(rel_o) < cnt_i)); // R7
  AST_REL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !last_o |=> busy_o && (rel_o == $past(rel_o) + WIDX_W'(1))); // R7
endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
  parameter int N_ENT      = 8,
  parameter int LINE_W     = 26,
  parameter int ID_W       = 4,
  parameter int LVL_W      = 2,
  parameter int LINE_WORDS = 8,
  parameter int DATA_W     = 32,
  parameter int MAX_WAIT   = 4,
  localparam int IDX_W     = $clog2(N_ENT),
  localparam int WORD_W    = $clog2(LINE_WORDS),
  localparam int LDATA_W   = LINE_WORDS * DATA_W,
  localparam int CNT_W     = $clog2(MAX_WAIT + 1),
  localparam int WIDX_W    = $clog2(MAX_WAIT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               miss_valid_i,
  input  logic [LINE_W-1:0]  miss_line_i,
  input  logic [ID_W-1:0]    miss_id_i,
  input  logic [WORD_W-1:0]  miss_word_i,
  input  logic [LVL_W-1:0]   miss_level_i,
  output logic               miss_ready_o,
  output logic               table_full_o,
  output logic               fetch_valid_o,
  output logic [LINE_W-1:0]  fetch_line_o,
  output logic [LVL_W-1:0]   fetch_level_o,
  output logic [IDX_W-1:0]   fetch_tag_o,
  input  logic               fill_valid_i,
  input  logic [IDX_W-1:0]   fill_tag_i,
  input  logic [LDATA_W-1:0] fill_data_i,
  output logic               fill_ready_o,
  output logic               resp_valid_o,
  output logic [ID_W-1:0]    resp_id_o,
  output logic [LVL_W-1:0]   resp_level_o,
  output logic [DATA_W-1:0]  resp_data_o
);
  import mshr_pkg::*;

  logic [N_ENT-1:0]                         ent_valid;
  logic [N_ENT-1:0][LINE_W-1:0]             ent_line;
  logic [N_ENT-1:0][LVL_W-1:0]              ent_level;
  logic [N_ENT-1:0][CNT_W-1:0]              ent_cnt;
  logic [N_ENT-1:0][MAX_WAIT-1:0][ID_W-1:0]   ent_ids;
  logic [N_ENT-1:0][MAX_WAIT-1:0][WORD_W-1:0] ent_words;

  logic             hit, free_any;
  logic [IDX_W-1:0] hit_idx, free_idx;
  miss_act_e        act;

  logic               drn_busy, drn_last;
  logic [IDX_W-1:0]   drn_tag;
  logic [WIDX_W-1:0]  drn_rel;
  logic [LDATA_W-1:0] drn_data;
  logic [WORD_W-1:0]  drn_word;

  mshr_lookup #(.N_ENT(N_ENT), .LINE_W(LINE_W)) u_lookup (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (ent_valid),
    .lines_i    (ent_line),
    .line_i     (miss_line_i),
    .hit_o      (hit),
    .hit_idx_o  (hit_idx),
    .free_any_o (free_any),
    .free_idx_o (free_idx)
  );

  // merge needs room and an entry not currently being returned
  always_comb begin
    if (!miss_valid_i)
      act = MISS_IDLE;
    else if (hit)
      act = (ent_cnt[hit_idx] < CNT_W'(MAX_WAIT) && !(drn_busy && drn_tag == hit_idx))
            ? MISS_MERGE : MISS_STALL;
    else
      act = free_any ? MISS_ALLOC : MISS_STALL;
  end

  assign miss_ready_o  = (act == MISS_MERGE) || (act == MISS_ALLOC);
  assign fetch_valid_o = (act == MISS_ALLOC);
  assign fetch_line_o  = miss_line_i;
  assign fetch_level_o = miss_level_i;
  assign fetch_tag_o   = free_idx;
  assign table_full_o  = !free_any;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    mshr_entry #(
      .LINE_W(LINE_W), .ID_W(ID_W), .WORD_W(WORD_W),
      .LVL_W(LVL_W), .MAX_WAIT(MAX_WAIT)
    ) u_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .alloc_i (act == MISS_ALLOC && free_idx == IDX_W'(g)),
      .merge_i (act == MISS_MERGE && hit_idx == IDX_W'(g)),
      .free_i  (drn_last && drn_tag == IDX_W'(g)),
      .line_i  (miss_line_i),
      .level_i (miss_level_i),
      .id_i    (miss_id_i),
      .word_i  (miss_word_i),
      .valid_o (ent_valid[g]),
      .line_o  (ent_line[g]),
      .level_o (ent_level[g]),
      .cnt_o   (ent_cnt[g]),
      .ids_o   (ent_ids[g]),
      .words_o (ent_words[g])
    );
  end

  mshr_drain #(.N_ENT(N_ENT), .MAX_WAIT(MAX_WAIT), .LDATA_W(LDATA_W)) u_drain (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_valid_i (fill_valid_i),
    .fill_tag_i   (fill_tag_i),
    .fill_data_i  (fill_data_i),
    .tag_live_i   (ent_valid[fill_tag_i]),
    .cnt_i        (ent_cnt[drn_tag]),
    .fill_ready_o (fill_ready_o),
    .busy_o       (drn_busy),
    .tag_o        (drn_tag),
    .rel_o        (drn_rel),
    .data_o       (drn_data),
    .last_o       (drn_last)
  );

  assign drn_word     = ent_words[drn_tag][drn_rel];
  assign resp_valid_o = drn_busy;
  assign resp_id_o    = ent_ids[drn_tag][drn_rel];
  assign resp_level_o = ent_level[drn_tag];
  assign resp_data_o  = drn_data[drn_word * DATA_W +: DATA_W];

  AST_FETCH_NEW_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |-> !hit); // R3
  AST_FULL_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    table_full_o |-> !fetch_valid_o); // R6
  AST_FREE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drn_last |=> !ent_valid[$past(drn_tag)]); // R8
  AST_RESP_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> ent_valid[drn_tag]); // R7
endmodule

// File: tb/mshr_file_bench.sv
module mshr_file_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         miss_valid = 1'b0;
  logic [25:0]  miss_line = '0;
  logic [3:0]   miss_id = '0;
  logic [2:0]   miss_word = '0;
  logic [1:0]   miss_level = '0;
  logic         miss_ready, table_full, fetch_valid;
  logic [25:0]  fetch_line;
  logic [1:0]   fetch_level;
  logic [2:0]   fetch_tag;
  logic         fill_valid = 1'b0;
  logic [2:0]   fill_tag = '0;
  logic [255:0] fill_data = '0;
  logic         fill_ready, resp_valid;
  logic [3:0]   resp_id;
  logic [1:0]   resp_level;
  logic [31:0]  resp_data;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mshr_file u_mshr_file (
    .clk_i(clk), .rst_ni(rst_n),
    .miss_valid_i(miss_valid), .miss_line_i(miss_line), .miss_id_i(miss_id),
    .miss_word_i(miss_word), .miss_level_i(miss_level),
    .miss_ready_o(miss_ready), .table_full_o(table_full),
    .fetch_valid_o(fetch_valid), .fetch_line_o(fetch_line),
    .fetch_level_o(fetch_level), .fetch_tag_o(fetch_tag),
    .fill_valid_i(fill_valid), .fill_tag_i(fill_tag), .fill_data_i(fill_data),
    .fill_ready_o(fill_ready), .resp_valid_o(resp_valid), .resp_id_o(resp_id),
    .resp_level_o(resp_level), .resp_data_o(resp_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wpat(input logic [2:0] tag, input int k);
    return {8'hA5, 5'd0, tag, 8'h3C, 8'(k)};
  endfunction

  function automatic logic [255:0] mk_line(input logic [2:0] tag);
    logic [255:0] d;
    for (int k = 0; k < 8; k++) d[k*32 +: 32] = wpat(tag, k);
    return d;
  endfunction

  task automatic miss(input logic [25:0] line, input logic [3:0] id,
                      input logic [2:0] word, input logic [1:0] lvl,
                      input bit exp_ready, input bit exp_fetch,
                      input logic [2:0] exp_tag, input string req);
    @(negedge clk);
    miss_valid = 1'b1; miss_line = line; miss_id = id;
    miss_word = word; miss_level = lvl;
    #2;
    chk(req, "miss_ready", 64'(miss_ready), 64'(exp_ready));
    chk(req, "fetch_valid", 64'(fetch_valid), 64'(exp_fetch));
    if (exp_fetch) begin
      chk(req, "fetch_tag", 64'(fetch_tag), 64'(exp_tag));
      chk(req, "fetch_line", 64'(fetch_line), 64'(line));
      chk(req, "fetch_level", 64'(fetch_level), 64'(lvl));
    end
    @(posedge clk); #1;
    miss_valid = 1'b0;
  endtask

  task automatic fill(input logic [2:0] tag, input int n,
                      input logic [3:0] ids [4], input logic [2:0] words [4],
                      input logic [1:0] lvl, input int full_last, input string req);
    @(negedge clk);
    fill_valid = 1'b1; fill_tag = tag; fill_data = mk_line(tag);
    #2;
    chk(req, "fill_ready", 64'(fill_ready), 64'd1);
    @(posedge clk); #1;
    fill_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #2;
      chk(req, "resp_valid", 64'(resp_valid), 64'd1);
      chk(req, "resp_id", 64'(resp_id), 64'(ids[k]));
      chk(req, "resp_data", 64'(resp_data), 64'(wpat(tag, int'(words[k]))));
      chk(req, "resp_level", 64'(resp_level), 64'(lvl));
      if (k == n - 1 && full_last >= 0)
        chk("R8", "table_full during last release", 64'(table_full), 64'(full_last));
    end
    @(negedge clk); #2;
    chk(req, "resp_valid after drain", 64'(resp_valid), 64'd0);
    chk(req, "fill_ready after drain", 64'(fill_ready), 64'd1);
  endtask

  task automatic t_reset;
    @(negedge clk); #2;
    chk("R1", "table_full", 64'(table_full), 64'd0);
    chk("R1", "fetch_valid", 64'(fetch_valid), 64'd0);
    chk("R1", "resp_valid", 64'(resp_valid), 64'd0);
    chk("R1", "fill_ready", 64'(fill_ready), 64'd1);
  endtask

  task automatic t_alloc_merge;
    miss(26'd100, 4'd1, 3'd2, 2'd1, 1, 1, 3'd0, "R2");
    miss(26'd200, 4'd2, 3'd5, 2'd2, 1, 1, 3'd1, "R2");
    miss(26'd100, 4'd3, 3'd7, 2'd1, 1, 0, 3'd0, "R3");
    miss(26'd200, 4'd4, 3'd0, 2'd2, 1, 0, 3'd0, "R3");
    // later line returns first
    fill(3'd1, 2, '{4'd2, 4'd4, 4'd0, 4'd0}, '{3'd5, 3'd0, 3'd0, 3'd0}, 2'd2, -1, "R10");
    fill(3'd0, 2, '{4'd1, 4'd3, 4'd0, 4'd0}, '{3'd2, 3'd7, 3'd0, 3'd0}, 2'd1, -1, "R7");
  endtask

  task automatic t_cap;
    miss(26'd300, 4'd5, 3'd1, 2'd0, 1, 1, 3'd0, "R2");
    miss(26'd300, 4'd6, 3'd3, 2'd0, 1, 0, 3'd0, "R3");
    miss(26'd300, 4'd7, 3'd5, 2'd0, 1, 0, 3'd0, "R3");
    miss(26'd300, 4'd8, 3'd7, 2'd0, 1, 0, 3'd0, "R3");
    miss(26'd300, 4'd9, 3'd4, 2'd0, 0, 0, 3'd0, "R5");
    fill(3'd0, 4, '{4'd5, 4'd6, 4'd7, 4'd8}, '{3'd1, 3'd3, 3'd5, 3'd7}, 2'd0, -1, "R5");
  endtask

  task automatic t_full;
    for (int i = 0; i < 8; i++)
      miss(26'(400 + i), 4'(i), 3'(i), 2'd3, 1, 1, 3'(i), "R2");
    @(negedge clk); #2;
    chk("R6", "table_full", 64'(table_full), 64'd1);
    miss(26'd500, 4'd11, 3'd0, 2'd3, 0, 0, 3'd0, "R6");
    miss(26'd403, 4'd12, 3'd6, 2'd3, 1, 0, 3'd0, "R6");
    fill(3'd5, 1, '{4'd5, 4'd0, 4'd0, 4'd0}, '{3'd5, 3'd0, 3'd0, 3'd0}, 2'd3, 1, "R7");
    chk("R8", "table_full after free", 64'(table_full), 64'd0);
    miss(26'd600, 4'd13, 3'd4, 2'd2, 1, 1, 3'd5, "R8");
    for (int i = 0; i < 8; i++) begin
      if (i == 3)
        fill(3'd3, 2, '{4'd3, 4'd12, 4'd0, 4'd0}, '{3'd3, 3'd6, 3'd0, 3'd0}, 2'd3, -1, "R7");
      else if (i == 5)
        fill(3'd5, 1, '{4'd13, 4'd0, 4'd0, 4'd0}, '{3'd4, 3'd0, 3'd0, 3'd0}, 2'd2, -1, "R8");
      else
        fill(3'(i), 1, '{4'(i), 4'd0, 4'd0, 4'd0}, '{3'(i), 3'd0, 3'd0, 3'd0}, 2'd3, -1, "R10");
    end
  endtask

  task automatic t_drain_block;
    miss(26'd700, 4'd1, 3'd1, 2'd1, 1, 1, 3'd0, "R2");
    miss(26'd700, 4'd2, 3'd2, 2'd1, 1, 0, 3'd0, "R3");
    @(negedge clk);
    fill_valid = 1'b1; fill_tag = 3'd0; fill_data = mk_line(3'd0);
    @(posedge clk); #1;
    fill_valid = 1'b0;
    @(negedge clk);
    miss_valid = 1'b1; miss_line = 26'd700; miss_id = 4'd3; miss_word = 3'd3; miss_level = 2'd1;
    #2;
    chk("R9", "fill_ready while draining", 64'(fill_ready), 64'd0);
    chk("R9", "miss to draining line", 64'(miss_ready), 64'd0);
    chk("R9", "no fetch", 64'(fetch_valid), 64'd0);
    chk("R7", "first resp id", 64'(resp_id), 64'd1);
    @(posedge clk); #1;
    miss_valid = 1'b0;
    @(negedge clk); #2;
    chk("R7", "second resp id", 64'(resp_id), 64'd2);
    chk("R7", "second resp data", 64'(resp_data), 64'(wpat(3'd0, 2)));
    @(negedge clk); #2;
    chk("R9", "drain ended, no third waiter", 64'(resp_valid), 64'd0);
  endtask

  task automatic t_bad_fill;
    @(negedge clk);
    fill_valid = 1'b1; fill_tag = 3'd3; fill_data = mk_line(3'd3);
    @(posedge clk); #1;
    fill_valid = 1'b0;
    @(negedge clk); #2;
    chk("R11", "no resp for empty entry", 64'(resp_valid), 64'd0);
    chk("R11", "fill_ready stays", 64'(fill_ready), 64'd1);
    miss(26'd800, 4'd4, 3'd0, 2'd0, 1, 1, 3'd0, "R11");
    fill(3'd0, 1, '{4'd4, 4'd0, 4'd0, 4'd0}, '{3'd0, 3'd0, 3'd0, 3'd0}, 2'd0, -1, "R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_alloc_merge();
    t_cap();
    t_full();
    t_drain_block();
    t_bad_fill();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule